// File: doc/BRIEF.md
# Divided-Clock Word Bridge

This block derives a slow timing domain from a fast clock by dividing it by an integer ratio, and carries data words from that slow domain into the fast one. The slow domain is represented inside the fast clock as a one-cycle tick every `DIV` fast cycles. The block also produces a square-ish slow clock level, a pass-through of the fast clock, and a reset for the slow domain that is derived from the fast reset.

Slow-side logic offers a word together with `wr_en_i`. The word is taken only in a cycle where `wr_rdy_o` is high. That flag is only ever high in the cycle that carries a slow edge. Fast-side logic sees the oldest stored word on `rd_data_o` whenever `rd_valid_o` is high, and can remove it in any fast cycle with `rd_en_i`.

Both domains come from the same oscillator, so the crossing needs no multi-flop synchronizer. It is qualified only by the divider's ready flag and passes through a two-entry store. Each word is held in one register row and becomes visible as a whole.

Top module: `ratio_clk_bridge`

## Requirements
- R1: Counting fast cycles n from 0 after reset release, `clk_rdy_o` is high exactly when n mod DIV equals DIV-1, so ticks are one cycle wide and DIV cycles apart (DIV >= 2; 3, 13 and 52 supported).
- R2: `slow_clk_o` is high exactly when n mod DIV is below DIV/2 (integer division), so it rises on the edge that closes a tick cycle; `fast_clk_o` follows `clk`.
- R3: `slow_rst_o` is high while `rst` is high and stays high up to and including the first tick cycle; it is low from cycle n = DIV on.
- R4: `wr_rdy_o` is high exactly when `clk_rdy_o` is high, `slow_rst_o` is low and fewer than 2 words are stored.
- R5: A word is stored only at a clock edge where `wr_en_i` and `wr_rdy_o` are both high; `wr_en_i` in any other cycle has no effect on the stored contents.
- R6: The store holds at most 2 words; with 2 words held, `wr_rdy_o` stays low even on a tick.
- R7: `rd_valid_o` is high exactly when at least one word is stored; `rd_en_i` with `rd_valid_o` high removes the oldest word at that edge in any fast cycle, and `rd_en_i` with nothing stored is ignored.
- R8: Words leave in the order they were accepted, none lost and none repeated.
- R9: An accepted word written into an empty store appears complete on `rd_data_o` in the next cycle; while `rd_valid_o` is high and no dequeue occurs, `rd_data_o` does not change.
- R10: While `rst` is high, `clk_rdy_o` and `rd_valid_o` and `wr_rdy_o` are low and `slow_rst_o` and `slow_clk_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset, fast domain |
| fast_clk_o | output | 1 | Fast clock passed through |
| slow_clk_o | output | 1 | Divided clock level |
| clk_rdy_o | output | 1 | High in the fast cycle ending on a slow rising edge |
| slow_rst_o | output | 1 | Reset for slow-domain logic |
| wr_en_i | input | 1 | Slow-side word offered |
| wr_data_i | input | DW | Slow-side word |
| wr_rdy_o | output | 1 | Slow-side word is taken this cycle if offered |
| rd_en_i | input | 1 | Fast-side dequeue request |
| rd_data_o | output | DW | Oldest stored word |
| rd_valid_o | output | 1 | At least one word stored |

## Verification
The bench runs the bridge at ratios 3, 13 and 52 side by side, each against a behavioural queue model compared every cycle. It first offers words on every cycle with reads held off, which fills the store and shows that off-tick and full-store offers are dropped. It then applies rare random dequeues, which keeps the store near full so that simultaneous enqueue and dequeue occur. Next it dequeues on every cycle, so each word is seen the cycle after it lands. A final drain with no offers shows that nothing is lost or repeated.

// File: rtl/ratio_bridge_pkg.sv
package ratio_bridge_pkg;
  // Entries in the crossing store; must be a power of two.
  localparam int unsigned XFER_DEPTH = 2;
  // Default word width.
  localparam int unsigned XFER_WIDTH = 16;
endpackage

// File: rtl/ratio_tick_gen.sv
module ratio_tick_gen #(
  parameter int unsigned DIV = 3
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic slow_clk_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  // Outputs are registered from the next phase value so they line up with cnt_q.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      tick_o     <= 1'b0;
      slow_clk_o <= 1'b1;
    end else begin
      cnt_q      <= cnt_d;
      tick_o     <= (cnt_d == LAST);
      slow_clk_o <= (cnt_d < HALF);
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R1
  AST_TICK_SLOW_LOW: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> !slow_clk_o); // R2
  AST_SLOW_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_clk_o) |-> $past(tick_o)); // R2
endmodule

// File: rtl/slow_reset_gen.sv
module slow_reset_gen (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic srst_o
);
  // Held while the fast reset is high, released on the first slow edge after it.
  always_ff @(posedge clk) begin
    if (rst)         srst_o <= 1'b1;
    else if (tick_i) srst_o <= 1'b0;
  end

  AST_SRST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(srst_o) |-> $past(tick_i)); // R3
  AST_SRST_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    !srst_o |=> !srst_o); // R3
endmodule

// File: rtl/ratio_word_fifo.sv
module ratio_word_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_req_i,
  output logic          full_o,
  output logic          valid_o,
  output logic [DW-1:0] head_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] LVL_FULL = (PW + 1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q;
  logic [PW-1:0] rptr_q;
  logic [PW:0]   level_q;
  logic          pop;

  assign pop = pop_req_i && (level_q != '0);

  // Storage has no reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push_i) mem[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + 1'b1;
      if (pop)    rptr_q <= rptr_q + 1'b1;
      case ({push_i, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign full_o  = (level_q == LVL_FULL);
  assign valid_o = (level_q != '0);
  assign head_o  = mem[rptr_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push_i |-> (level_q < LVL_FULL)); // R6
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !pop_req_i) |=> (valid_o && $stable(head_o))); // R9
  AST_LAND_NEXT: assert property (@(posedge clk) disable iff (rst)
    push_i |=> valid_o); // R9
endmodule

// File: rtl/ratio_clk_bridge.sv
module ratio_clk_bridge
  import ratio_bridge_pkg::*;
#(
  parameter int unsigned DIV   = 3,
  parameter int unsigned DW    = XFER_WIDTH,
  parameter int unsigned DEPTH = XFER_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  output logic          fast_clk_o,
  output logic          slow_clk_o,
  output logic          clk_rdy_o,
  output logic          slow_rst_o,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_rdy_o,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  logic tick;
  logic srst;
  logic full;
  logic push;

  assign fast_clk_o = clk;

  ratio_tick_gen #(.DIV(DIV)) u_div (
    .clk        (clk),
    .rst        (rst),
    .tick_o     (tick),
    .slow_clk_o (slow_clk_o)
  );

  slow_reset_gen u_srst (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .srst_o (srst)
  );

  // Both sides share one oscillator: the tick alone qualifies the crossing.
  assign wr_rdy_o   = tick && !srst && !full;
  assign push       = wr_en_i && wr_rdy_o;
  assign clk_rdy_o  = tick;
  assign slow_rst_o = srst;

  ratio_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push),
    .push_data_i (wr_data_i),
    .pop_req_i   (rd_en_i),
    .full_o      (full),
    .valid_o     (rd_valid_o),
    .head_o      (rd_data_o)
  );

  AST_PUSH_IN_SLOW_RUN: assert property (@(posedge clk) disable iff (rst)
    push |-> !slow_rst_o); // R5
endmodule

// File: tb/sim_ratio_clk_bridge.sv
`timescale 1ns/1ps
module bridge_lane #(
  parameter int unsigned DIV = 3
) (
  input  logic clk,
  output int   n_chk,
  output int   n_bad,
  output logic done
);
  localparam int unsigned DW = 16;

  logic          rst;
  logic          fast_clk_o, slow_clk_o, clk_rdy_o, slow_rst_o;
  logic          wr_en, wr_rdy, rd_en, rd_valid;
  logic [DW-1:0] wr_data, rd_data;

  ratio_clk_bridge #(.DIV(DIV), .DW(DW), .DEPTH(2)) u0 (
    .clk        (clk),
    .rst        (rst),
    .fast_clk_o (fast_clk_o),
    .slow_clk_o (slow_clk_o),
    .clk_rdy_o  (clk_rdy_o),
    .slow_rst_o (slow_rst_o),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .wr_rdy_o   (wr_rdy),
    .rd_en_i    (rd_en),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s DIV=%0d actual=%0h expected=%0h", req, DIV, act, exp);
    end
  endtask

  initial begin
    logic [DW-1:0] q[$];
    int  last_tick;
    int  pushed, popped;
    bit  landed;
    logic [DW-1:0] landed_word;
    n_chk = 0; n_bad = 0; done = 0;
    rst = 1; wr_en = 0; rd_en = 0; wr_data = '0;
    pushed = 0; popped = 0; last_tick = -1; landed = 0; landed_word = '0;
    repeat (3) @(negedge clk);
    // Reset state, R10
    chk(clk_rdy_o == 0, "R10 clk_rdy", clk_rdy_o, 0);
    chk(rd_valid == 0, "R10 rd_valid", rd_valid, 0);
    chk(wr_rdy == 0, "R10 wr_rdy", wr_rdy, 0);
    chk(slow_rst_o == 1, "R10 slow_rst", slow_rst_o, 1);
    chk(slow_clk_o == 1, "R10 slow_clk", slow_clk_o, 1);
    rst = 0;
    for (int n = 0; n < 60 * int'(DIV); n++) begin
      bit e_tick, e_slow, e_srst, e_wrdy, deq, acc;
      int ph;
      ph     = n % int'(DIV);
      e_tick = (ph == int'(DIV) - 1);
      e_slow = (ph < int'(DIV / 2));
      e_srst = (n < int'(DIV));
      e_wrdy = e_tick && !e_srst && (q.size() < 2);
      chk(clk_rdy_o == e_tick, "R1 tick", clk_rdy_o, e_tick);
      if (clk_rdy_o) begin
        if (last_tick >= 0) chk(n - last_tick == int'(DIV), "R1 period", n - last_tick, DIV);
        last_tick = n;
      end
      chk(slow_clk_o == e_slow, "R2 slow_clk", slow_clk_o, e_slow);
      chk(fast_clk_o == 1'b0, "R2 fast_clk", fast_clk_o, 0);
      chk(slow_rst_o == e_srst, "R3 slow_rst", slow_rst_o, e_srst);
      chk(wr_rdy == e_wrdy, "R4 wr_rdy", wr_rdy, e_wrdy);
      if (q.size() == 2 && e_tick) chk(wr_rdy == 0, "R6 full", wr_rdy, 0);
      chk(rd_valid == (q.size() > 0), "R7 rd_valid", rd_valid, q.size() > 0);
      if (q.size() > 0) chk(rd_data == q[0], "R8 order", rd_data, q[0]);
      if (landed) chk(rd_valid && rd_data == landed_word, "R9 landing", rd_data, landed_word);
      // Stimulus by phase
      wr_data = DW'($urandom);
      if (n < 8 * int'(DIV)) begin
        wr_en = 1; rd_en = 0;
      end else if (n < 40 * int'(DIV)) begin
        wr_en = ($urandom % 2) == 0; rd_en = ($urandom % 8) == 0;
      end else if (n < 50 * int'(DIV)) begin
        wr_en = ($urandom % 3) != 0; rd_en = 1;
      end else begin
        wr_en = 0; rd_en = ($urandom % 2) == 0;
      end
      // Model update for the coming edge, R5 R7
      deq = rd_en && (q.size() > 0);
      acc = wr_en && e_wrdy;
      landed = acc && (q.size() == 0 || (q.size() == 1 && deq));
      landed_word = wr_data;
      if (deq) begin void'(q.pop_front()); popped++; end
      if (acc) begin q.push_back(wr_data); pushed++; end
      @(negedge clk);
      if (wr_en && !acc) chk(rd_valid == (q.size() > 0), "R5 ignored", rd_valid, q.size() > 0);
      if (rd_en && !deq) chk(rd_valid == (q.size() > 0), "R7 empty deq", rd_valid, q.size() > 0);
    end
    chk(q.size() == 0, "R8 drained", q.size(), 0);
    chk(pushed == popped, "R8 count", popped, pushed);
    chk(pushed > 10, "R8 traffic", pushed, 11);
    done = 1;
  end
endmodule

module sim_ratio_clk_bridge;
  logic clk = 0;
  int c0, b0, c1, b1, c2, b2;
  logic d0, d1, d2;

  always #4 clk = ~clk;

  bridge_lane #(.DIV(3))  l3  (.clk(clk), .n_chk(c0), .n_bad(b0), .done(d0));
  bridge_lane #(.DIV(13)) l13 (.clk(clk), .n_chk(c1), .n_bad(b1), .done(d1));
  bridge_lane #(.DIV(52)) l52 (.clk(clk), .n_chk(c2), .n_bad(b2), .done(d2));

  initial begin
    int guard;
    int wd_bad;
    guard = 0; wd_bad = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && guard < 100000) begin
      @(posedge clk);
      guard++;
    end
    if (guard >= 100000) begin
      wd_bad = 1;
      $display("FAIL watchdog actual=%0d expected=done", guard);
    end
    #1;
    $display("test done: total=%0d bad=%0d", c0 + c1 + c2 + wd_bad, b0 + b1 + b2 + wd_bad);
    $finish;
  end
endmodule